// File: doc/BRIEF.md
# Enabled Highest-Index Request Encoder

The block watches a small group of request lines and reports, as a binary number, the position of the highest-numbered line that is currently high. When no line is high, the reported number is zero. A separate flag then shows that this zero does not belong to an actual request. A single enable input can silence the whole block. While the enable is low, the number and the flag are both held at zero, whatever the request lines do.

The selection logic is purely combinational. Its result passes through one register stage clocked on the rising edge, so every output reflects the inputs that were present one edge earlier. That register clears to zero under a synchronous, active-low reset. The number of request lines is a parameter. With the default of four lines the code is two bits wide.

Top module: `hiprio_encoder`

## Requirements
- R1: With enable high and exactly one request line high, the code output equals the position of that line (line 0 gives 0, line 3 gives 3, on the 2-bit code).
- R2: With enable high and several request lines high, the code output equals the position of the highest-numbered active line.
- R3: With enable high and every request line low, the code output is 0 and the idle flag is 1.
- R4: With enable high and at least one request line high, the idle flag is 0.
- R5: With enable low, the code output and the idle flag are both 0, for any pattern on the request lines.
- R6: The outputs change only on a rising clock edge and show the result for the inputs sampled at that edge. A change on the inputs between edges does not reach the outputs.
- R7: While the active-low reset is low at a rising edge, the code output and the idle flag become 0, whatever the enable and request inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_REQ (4) | Request lines; bit i is request i |
| en_i | input | 1 | Enable; low forces all outputs to 0 |
| code_o | output | CODE_W (2) | Registered position of the highest active request |
| idle_o | output | 1 | Registered flag: enabled and no request active |

## Verification
The bench steps through all 32 combinations of the enable and the four request lines, and checks each registered result against an expected-value table. The single-line patterns show that every position maps to its own code. The patterns with several lines high show that the highest position wins over lower ones. The all-low pattern with enable high is the only case that sets the idle flag. The sixteen disabled patterns, which include the all-high one, show that the enable overrides every request. Directed tests then apply reset while requests are active, and change an input between edges to confirm the one-edge latency.

// File: rtl/hiprio_pkg.sv
// Package hiprio_pkg
// Holds the shared defaults and width arithmetic for the highest-index
// request encoder. It assumes at least one request line.
package hiprio_pkg;

    localparam int HP_DEF_REQ = 4;

    // Width of a code that can name any of n request lines.
    function automatic int hp_code_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hiprio_scan.sv
// Module hiprio_scan
// Finds the highest-numbered active request and reports whether any line
// is active. Combinational. It assumes NUM_REQ >= 1, and CODE_W must hold
// NUM_REQ-1.
module hiprio_scan #(
    parameter int NUM_REQ = hiprio_pkg::HP_DEF_REQ,
    parameter int CODE_W  = hiprio_pkg::hp_code_w(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic [CODE_W-1:0]  pos_o,
    output logic               any_o
);

    // Upward scan: a later (higher) hit overrides earlier ones.
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_i[i]) pos_o = CODE_W'(i);
        end
    end

    // Any-request detection for the idle flag.
    always_comb any_o = |req_i;

    // The reported position must point at an active line (R1, R2).
    always_comb begin
        if (any_o) begin
            assert_pos_is_active_R1: assert (req_i[pos_o]);
        end
    end

endmodule

// File: rtl/hiprio_gate.sv
// Module hiprio_gate
// Applies the enable to the scan result and forms the idle flag.
// Combinational. It assumes the scan inputs are settled.
module hiprio_gate #(
    parameter int CODE_W = 2
) (
    input  logic              en_i,
    input  logic [CODE_W-1:0] pos_i,
    input  logic              any_i,
    output logic [CODE_W-1:0] code_o,
    output logic              idle_o
);

    // Disabled: everything is zero. Enabled: pass the code and flag no-request.
    always_comb begin
        code_o = en_i ? pos_i : '0;
        idle_o = en_i & ~any_i;
    end

    // An idle indication never comes with a nonzero code (R3).
    always_comb begin
        if (idle_o) begin
            assert_idle_code_zero_R3: assert (code_o == '0);
        end
    end

endmodule

// File: rtl/hiprio_outreg.sv
// Module hiprio_outreg
// Output register for the encoder result. It loads on every rising edge
// and clears under a synchronous active-low reset. It assumes clk runs freely.
module hiprio_outreg #(
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);

    // Capture the combinational result, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end

    // One edge of latency from the data input to the output (R6).
    assert_follow_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q_o == $past(d_i)));

    // A reset edge leaves the output cleared (R7).
    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0));

endmodule

// File: rtl/hiprio_encoder.sv
// Module hiprio_encoder
// Top: a registered encoder that gives the highest active request, with an
// enable and an idle flag. It assumes a synchronous active-low reset.
module hiprio_encoder #(
    parameter int NUM_REQ = hiprio_pkg::HP_DEF_REQ,
    parameter int CODE_W  = hiprio_pkg::hp_code_w(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               en_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               idle_o
);

    localparam int OUT_W = CODE_W + 1;
    localparam logic [CODE_W-1:0] TOP_POS = CODE_W'(NUM_REQ - 1);

    logic [CODE_W-1:0] pos;
    logic              any_req;
    logic [CODE_W-1:0] code_d;
    logic              idle_d;
    logic [OUT_W-1:0]  out_q;

    hiprio_scan #(.NUM_REQ(NUM_REQ), .CODE_W(CODE_W)) u_scan (
        .req_i (req_i),
        .pos_o (pos),
        .any_o (any_req)
    );

    hiprio_gate #(.CODE_W(CODE_W)) u_gate (
        .en_i   (en_i),
        .pos_i  (pos),
        .any_i  (any_req),
        .code_o (code_d),
        .idle_o (idle_d)
    );

    hiprio_outreg #(.DW(OUT_W)) u_outreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({idle_d, code_d}),
        .q_o   (out_q)
    );

    // Split the registered word back into the code and the flag.
    always_comb begin
        code_o = out_q[CODE_W-1:0];
        idle_o = out_q[OUT_W-1];
    end

    // A low enable yields all zeros on the next edge (R5).
    assert_disabled_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (code_o == '0 && !idle_o));

    // Any active request while enabled clears the idle flag (R4).
    assert_hit_not_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && |req_i) |=> !idle_o);

    // The top line wins over any other active line (R2).
    assert_top_line_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && req_i[NUM_REQ-1]) |=> (code_o == TOP_POS));

    // No request while enabled raises the flag (R3).
    assert_none_sets_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !(|req_i)) |=> (idle_o && code_o == '0));

endmodule

// File: tb/test_hiprio_encoder.sv
// Bench for hiprio_encoder: a table walk over every enable/request
// combination, then directed reset and latency tests.
module test_hiprio_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = 4'h0;
    logic       en = 1'b0;
    logic [1:0] code;
    logic       idle;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Entry: {en, req[3:0], idle, code[1:0]}; index = {en, req}.
    localparam logic [7:0] VEC [32] = '{
        8'b0_0000_000, 8'b0_0001_000, 8'b0_0010_000, 8'b0_0011_000,
        8'b0_0100_000, 8'b0_0101_000, 8'b0_0110_000, 8'b0_0111_000,
        8'b0_1000_000, 8'b0_1001_000, 8'b0_1010_000, 8'b0_1011_000,
        8'b0_1100_000, 8'b0_1101_000, 8'b0_1110_000, 8'b0_1111_000,
        8'b1_0000_100, 8'b1_0001_000, 8'b1_0010_001, 8'b1_0011_001,
        8'b1_0100_010, 8'b1_0101_010, 8'b1_0110_010, 8'b1_0111_010,
        8'b1_1000_011, 8'b1_1001_011, 8'b1_1010_011, 8'b1_1011_011,
        8'b1_1100_011, 8'b1_1101_011, 8'b1_1110_011, 8'b1_1111_011
    };

    hiprio_encoder i_hiprio_encoder (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .en_i   (en),
        .code_o (code),
        .idle_o (idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got idle/code=%b expected %b", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [4:0] stim);
        if (!stim[4])                return "R5";
        if (stim[3:0] == 4'h0)       return "R3";
        if ($countones(stim[3:0]) == 1) return "R1/R4";
        return "R2/R4";
    endfunction

    // Stimulus and checking.
    initial begin
        // R7: reset with active inputs holds outputs at zero.
        en = 1'b1; req = 4'hF;
        repeat (3) @(negedge clk);
        check("R7 reset with requests", {idle, code}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first cycle after reset", {idle, code}, 3'b011);

        // Table walk over all 32 combinations.
        for (int k = 0; k < 32; k++) begin
            {en, req} = VEC[k][7:3];
            @(negedge clk);
            check(tag_of(VEC[k][7:3]), {idle, code}, VEC[k][2:0]);
        end

        // R6: an input change between edges does not reach the outputs.
        en = 1'b1; req = 4'b0010;
        @(negedge clk);
        check("R6 settled value", {idle, code}, 3'b001);
        req = 4'b0000;
        #(CLK_PERIOD/4);
        check("R6 hold before edge", {idle, code}, 3'b001);
        @(negedge clk);
        check("R6 after edge", {idle, code}, 3'b100);

        // R5: the enable drops while every request is active.
        en = 1'b0; req = 4'hF;
        @(negedge clk);
        check("R5 disable overrides all", {idle, code}, 3'b000);

        // R7: reset mid-run with the idle flag set.
        en = 1'b1; req = 4'h0;
        @(negedge clk);
        check("R3 idle before reset", {idle, code}, 3'b100);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 mid-run reset", {idle, code}, 3'b000);
        rst_n = 1'b1; req = 4'b0001;
        @(negedge clk);
        check("R1 line 0 after reset", {idle, code}, 3'b000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule